// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block decides where each CPU memory access in the legacy area just below 1 MiB is sent. It holds the routing registers for that area and evaluates every access from its address, a write flag and a system-management-mode flag. The result is one of three outcomes: system DRAM, the expansion bus, or a dropped write.

The upper 256 KiB is split into a 64 KiB firmware area at 0xF0000 and twelve 16 KiB option segments from 0xC0000. Each of these has a 2-bit attribute field. The 128 KiB video window at 0xA0000 follows a separate control byte, which can open it to DRAM always or only while the CPU is in management mode.

Software reaches the registers through a byte-wide configuration port. The same port returns a read-only byte giving installed memory in 8 MiB units. Routing is combinational on the access inputs, so a change of the mode flag acts at once. A configuration write acts from the clock edge that stores it.

Top module: `lmad_attr_dec`

## Requirements
- R1: After reset every attribute byte (offsets 0x59..0x5F) reads 0x00 and the video control byte (offset 0x72) reads 0x02, so every access in 0xA0000..0xFFFFF goes to the bus.
- R2: Any address below 0xA0000 or at or above 0x100000 goes to DRAM for reads and writes, whatever the register contents or mode flag.
- R3: The firmware area 0xF0000..0xFFFFF uses bits [5:4] of byte 0x59. The other bits of that byte have no effect on routing.
- R4: Option segment i (0..11) covers 0xC0000+i*0x4000 up to the next 16 KiB boundary. Its field is in byte 0x5A+i/2, at bits [1:0] for even i and bits [5:4] for odd i.
- R5: Attribute 3 sends reads and writes to DRAM.
- R6: Attribute 1 sends reads to DRAM. A write is dropped: wr_drop_o=1 and neither route output is set.
- R7: Attribute 2 sends reads to the bus and writes to DRAM.
- R8: Attribute 0 sends reads and writes to the bus.
- R9: The video window 0xA0000..0xBFFFF goes to DRAM when bit 6 of byte 0x72 is set, or when smm_i=1 and bit 3 is set. Otherwise it goes to the bus. A change of smm_i takes effect in the same cycle.
- R10: For every access exactly one of dram_o, bus_o, wr_drop_o is 1, and wr_drop_o is 1 only on a write.
- R11: Byte 0x57 reads min(ram_mb_i/8, 255), rounded down, and ignores writes.
- R12: A configuration write stores the whole byte and steers routing from the next clock edge. Offsets other than 0x59..0x5F and 0x72 ignore writes and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data at cfg_addr_i |
| ram_mb_i | input | 16 | Installed memory in MiB |
| acc_addr_i | input | 32 | CPU access address |
| acc_we_i | input | 1 | Access is a write |
| smm_i | input | 1 | CPU in management mode |
| dram_o | output | 1 | Access goes to DRAM |
| bus_o | output | 1 | Access goes to the expansion bus |
| wr_drop_o | output | 1 | Write to a read-only region is discarded |

## Verification
The assertions assume that the access inputs describe one access per cycle and stay defined for the whole cycle. They also assume a configuration write touches one byte, so a write overlaps a register range only by naming an offset inside it. The bench drives every input on the falling edge with fixed-width values and writes one byte per strobe. Random addresses are biased into the 0xA0000..0xFFFFF window, and random offsets include unmapped and read-only bytes.

// File: rtl/lmad_pkg.sv
package lmad_pkg;
  typedef enum logic [1:0] {
    ATTR_BUS = 2'd0,
    ATTR_RO  = 2'd1,
    ATTR_WO  = 2'd2,
    ATTR_RW  = 2'd3
  } attr_e;

  typedef enum logic [1:0] {
    RGN_PLAIN = 2'd0,
    RGN_VIDEO = 2'd1,
    RGN_SEG   = 2'd2,
    RGN_FW    = 2'd3
  } rgn_e;

  localparam logic [7:0] TOM_OFS   = 8'h57;
  localparam logic [7:0] ATTR_OFS  = 8'h59;
  localparam logic [7:0] VCTL_OFS  = 8'h72;
  localparam logic [7:0] VCTL_RST  = 8'h02;
  localparam int         VCTL_OPEN = 6;
  localparam int         VCTL_SMM  = 3;
endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs #(
  parameter int ATTR_BYTES = 7,
  parameter int RAM_MB_W   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [7:0]              wdata_i,
  input  logic [RAM_MB_W-1:0]     ram_mb_i,
  output logic [7:0]              rdata_o,
  output logic [ATTR_BYTES*8-1:0] attr_o,
  output logic [7:0]              vctl_o
);
  import lmad_pkg::*;

  localparam int UNITS_W = (RAM_MB_W > 3) ? RAM_MB_W - 3 : 1;

  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] vctl_q;
  logic [7:0] tom;
  logic [UNITS_W-1:0] units;

  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    logic hit;
    assign hit = we_i && (addr_i == ATTR_OFS + 8'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  attr_q[b] <= '0;
      else if (hit) attr_q[b] <= wdata_i;
    end
    assign attr_o[b*8 +: 8] = attr_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           vctl_q <= VCTL_RST;
    else if (we_i && addr_i == VCTL_OFS)   vctl_q <= wdata_i;
  end
  assign vctl_o = vctl_q;

  // memory size in 8 MiB units, saturating
  assign units = UNITS_W'(ram_mb_i >> 3);
  assign tom   = (units > UNITS_W'(255)) ? 8'hFF : 8'(units);

  always_comb begin
    rdata_o = '0;
    if (addr_i == TOM_OFS)  rdata_o = tom;
    if (addr_i == VCTL_OFS) rdata_o = vctl_q;
    for (int b = 0; b < ATTR_BYTES; b++)
      if (addr_i == ATTR_OFS + 8'(b)) rdata_o = attr_q[b];
  end
endmodule

// File: rtl/lmad_seg_decode.sv
module lmad_seg_decode #(
  parameter int ADDR_W     = 32,
  parameter int N_SEG      = 12,
  parameter int ATTR_BYTES = 7
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ATTR_BYTES*8-1:0] attr_i,
  output lmad_pkg::rgn_e          rgn_o,
  output lmad_pkg::attr_e         attr_o
);
  import lmad_pkg::*;

  localparam int         IDX_W    = $clog2(N_SEG);
  localparam logic [5:0] SEG_BASE = 6'h30; // 0xC0000 >> 14

  logic [1:0] seg_fld [N_SEG];
  logic       above;
  logic [5:0] blk;
  logic [5:0] rel;

  // field i: byte 1+i/2, low nibble for even i, high nibble for odd i
  for (genvar i = 0; i < N_SEG; i++) begin : g_fld
    assign seg_fld[i] = attr_i[(1 + i/2)*8 + (i%2)*4 +: 2];
  end

  if (ADDR_W > 20) begin : g_hi
    assign above = |addr_i[ADDR_W-1:20];
  end else begin : g_nohi
    assign above = 1'b0;
  end

  assign blk = addr_i[19:14];
  assign rel = blk - SEG_BASE;

  always_comb begin
    rgn_o  = RGN_PLAIN;
    attr_o = ATTR_BUS;
    if (!above) begin
      if (addr_i[19:17] == 3'b101) begin
        rgn_o = RGN_VIDEO;
      end else if (addr_i[19:16] == 4'hF) begin
        rgn_o  = RGN_FW;
        attr_o = attr_e'(attr_i[5:4]);
      end else if (addr_i[19:18] == 2'b11) begin
        rgn_o = RGN_SEG;
        if (rel < 6'(N_SEG)) attr_o = attr_e'(seg_fld[rel[IDX_W-1:0]]);
      end
    end
  end
endmodule

// File: rtl/lmad_route.sv
module lmad_route (
  input  lmad_pkg::rgn_e  rgn_i,
  input  lmad_pkg::attr_e attr_i,
  input  logic            we_i,
  input  logic            smm_i,
  input  logic [7:0]      vctl_i,
  output logic            dram_o,
  output logic            bus_o,
  output logic            drop_o
);
  import lmad_pkg::*;

  logic video_open;
  assign video_open = vctl_i[VCTL_OPEN] | (smm_i & vctl_i[VCTL_SMM]);

  always_comb begin
    dram_o = 1'b0;
    bus_o  = 1'b0;
    drop_o = 1'b0;
    unique case (rgn_i)
      RGN_PLAIN: dram_o = 1'b1;
      RGN_VIDEO: begin
        dram_o = video_open;
        bus_o  = !video_open;
      end
      default: begin
        unique case (attr_i)
          ATTR_RW:  dram_o = 1'b1;
          ATTR_RO:  begin dram_o = !we_i; drop_o = we_i; end
          ATTR_WO:  begin dram_o = we_i;  bus_o  = !we_i; end
          default:  bus_o  = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/lmad_attr_dec.sv
module lmad_attr_dec #(
  parameter int ADDR_W     = 32,
  parameter int RAM_MB_W   = 16,
  parameter int N_SEG      = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic [RAM_MB_W-1:0] ram_mb_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic                acc_we_i,
  input  logic                smm_i,
  output logic                dram_o,
  output logic                bus_o,
  output logic                wr_drop_o
);
  import lmad_pkg::*;

  localparam int ATTR_BYTES = 1 + (N_SEG + 1) / 2;

  logic [ATTR_BYTES*8-1:0] attr_q;
  logic [7:0]              vctl_q;
  rgn_e                    rgn;
  attr_e                   attr;

  lmad_cfg_regs #(.ATTR_BYTES(ATTR_BYTES), .RAM_MB_W(RAM_MB_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .ram_mb_i (ram_mb_i),
    .rdata_o  (cfg_rdata_o),
    .attr_o   (attr_q),
    .vctl_o   (vctl_q)
  );

  lmad_seg_decode #(.ADDR_W(ADDR_W), .N_SEG(N_SEG), .ATTR_BYTES(ATTR_BYTES)) u_dec (
    .addr_i (acc_addr_i),
    .attr_i (attr_q),
    .rgn_o  (rgn),
    .attr_o (attr)
  );

  lmad_route u_route (
    .rgn_i  (rgn),
    .attr_i (attr),
    .we_i   (acc_we_i),
    .smm_i  (smm_i),
    .vctl_i (vctl_q),
    .dram_o (dram_o),
    .bus_o  (bus_o),
    .drop_o (wr_drop_o)
  );
endmodule

// File: rtl/lmad_chk.sv
module lmad_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [7:0]        cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_we_i,
  input logic              smm_i,
  input logic [7:0]        vctl_q,
  input logic [7:0]        attr0_q,
  input logic              dram_o,
  input logic              bus_o,
  input logic              wr_drop_o
);
  logic outside, video, fw;
  assign outside = (acc_addr_i < ADDR_W'(32'h000A_0000)) || (acc_addr_i >= ADDR_W'(32'h0010_0000));
  assign video   = !outside && acc_addr_i < ADDR_W'(32'h000C_0000);
  assign fw      = !outside && acc_addr_i >= ADDR_W'(32'h000F_0000);

  // R10
  one_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({dram_o, bus_o, wr_drop_o}) == 1);

  // R10
  drop_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> acc_we_i);

  // R2
  outside_dram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outside |-> dram_o);

  // R9
  video_smm_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (video && smm_i && vctl_q[3]) |-> dram_o);

  // R9
  video_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (video && !vctl_q[6] && !(smm_i && vctl_q[3])) |-> bus_o);

  // R8
  fw_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw && attr0_q[5:4] == 2'b00) |-> bus_o);

  // R12
  vctl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 8'h72) |=> vctl_q == $past(cfg_wdata_i));
endmodule

bind lmad_attr_dec lmad_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .acc_addr_i  (acc_addr_i),
  .acc_we_i    (acc_we_i),
  .smm_i       (smm_i),
  .vctl_q      (vctl_q),
  .attr0_q     (attr_q[7:0]),
  .dram_o      (dram_o),
  .bus_o       (bus_o),
  .wr_drop_o   (wr_drop_o)
);

// File: tb/tb_lmad_attr_dec.sv
module tb_lmad_attr_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] ram_mb = 16'd1000;
  logic [31:0] acc_addr = '0;
  logic        acc_we = 1'b0;
  logic        smm = 1'b0;
  logic        dram, bus, drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_attr [7];
  logic [7:0] m_vctl;

  always #10 clk = ~clk;

  lmad_attr_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .ram_mb_i(ram_mb),
    .acc_addr_i(acc_addr), .acc_we_i(acc_we), .smm_i(smm),
    .dram_o(dram), .bus_o(bus), .wr_drop_o(drop)
  );

  // route code {drop,bus,dram}: 1 dram, 2 bus, 4 drop
  function automatic logic [2:0] by_attr(logic [1:0] a, logic we);
    case (a)
      2'd3: return 3'b001;
      2'd1: return we ? 3'b100 : 3'b001;
      2'd2: return we ? 3'b001 : 3'b010;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [2:0] exp_route(logic [31:0] a, logic we, logic s);
    int i;
    if (a < 32'hA0000 || a >= 32'h100000) return 3'b001;
    if (a < 32'hC0000)
      return (m_vctl[6] || (s && m_vctl[3])) ? 3'b001 : 3'b010;
    if (a >= 32'hF0000) return by_attr(m_attr[0][5:4], we);
    i = int'((a - 32'hC0000) >> 14);
    return by_attr(m_attr[1 + i/2][(i%2)*4 +: 2], we);
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] o);
    if (o == 8'h57) return ((ram_mb >> 3) > 16'd255) ? 8'hFF : 8'(ram_mb >> 3);
    if (o == 8'h72) return m_vctl;
    if (o >= 8'h59 && o <= 8'h5F) return m_attr[o - 8'h59];
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [7:0] o, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = o; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (o == 8'h72) m_vctl = d;
    if (o >= 8'h59 && o <= 8'h5F) m_attr[o - 8'h59] = d;
  endtask

  task automatic acc(string req, logic [31:0] a, logic we, logic s);
    @(negedge clk);
    acc_addr = a; acc_we = we; smm = s;
    #5;
    check(req, {5'b0, drop, bus, dram}, {5'b0, exp_route(a, we, s)});
  endtask

  task automatic rd(string req, logic [7:0] o);
    @(negedge clk);
    cfg_addr = o;
    #5;
    check(req, cfg_rdata, exp_rd(o));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [12] = '{8'h57, 8'h58, 8'h59, 8'h5A, 8'h5B, 8'h5C,
                              8'h5D, 8'h5E, 8'h5F, 8'h60, 8'h72, 8'h73};
    void'($urandom(32'd1234));
    for (int b = 0; b < 7; b++) m_attr[b] = '0;
    m_vctl = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int o = 8'h59; o <= 8'h5F; o++) rd("R1 attr reset", 8'(o));
    rd("R1 vctl reset", 8'h72);
    acc("R1 video bus", 32'hA0000, 1'b0, 1'b1);
    acc("R1 seg bus", 32'hC0000, 1'b1, 1'b0);
    acc("R1 fw bus", 32'hFFFFF, 1'b0, 1'b0);
    // R2 outside
    acc("R2 low", 32'h9FFFF, 1'b1, 1'b0);
    acc("R2 high", 32'h100000, 1'b0, 1'b0);
    // R3 firmware field
    cfg_wr(8'h59, 8'h30);
    acc("R3 R5 fw rw read", 32'hF0000, 1'b0, 1'b0);
    acc("R3 R5 fw rw write", 32'hF8000, 1'b1, 1'b0);
    cfg_wr(8'h59, 8'hCF);
    acc("R3 other bits ignored", 32'hF1234, 1'b0, 1'b0);
    acc("R3 R8 fw bus write", 32'hF1234, 1'b1, 1'b0);
    // R4 R6 segment 3 read-only (byte 0x5B high nibble)
    cfg_wr(8'h5B, 8'h10);
    acc("R4 R6 seg3 read", 32'hCC000, 1'b0, 1'b0);
    acc("R4 R6 seg3 write drop", 32'hCFFFF, 1'b1, 1'b0);
    acc("R4 seg2 untouched", 32'hC8000, 1'b0, 1'b0);
    // R7 segment 10 write-only (byte 0x5F low nibble), R5 seg 11
    cfg_wr(8'h5F, 8'h32);
    acc("R4 R7 seg10 read bus", 32'hE8000, 1'b0, 1'b0);
    acc("R4 R7 seg10 write dram", 32'hEBFFF, 1'b1, 1'b0);
    acc("R4 R5 seg11 edge", 32'hEFFFF, 1'b1, 1'b0);
    // R9 video
    cfg_wr(8'h72, 8'h08);
    acc("R9 smm open", 32'hB0000, 1'b0, 1'b1);
    acc("R9 smm off", 32'hB0000, 1'b0, 1'b0);
    cfg_wr(8'h72, 8'h40);
    acc("R9 forced open", 32'hBFFFF, 1'b1, 1'b0);
    // R11 size byte
    rd("R11 1000MiB", 8'h57);
    ram_mb = 16'd2048;
    rd("R11 saturate", 8'h57);
    ram_mb = 16'd2047;
    rd("R11 floor", 8'h57);
    cfg_wr(8'h57, 8'h5A);
    rd("R11 write ignored", 8'h57);
    // R12 unmapped
    cfg_wr(8'h58, 8'hFF);
    rd("R12 unmapped reads 0", 8'h58);
    rd("R12 vctl full byte", 8'h72);

    // random mix, R10 via code compare
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 4 == 0) begin
        cfg_wr(offs[$urandom % 12], 8'($urandom));
        rd("R12 random readback", offs[$urandom % 12]);
      end else begin
        logic [31:0] a;
        a = ($urandom % 5 == 0) ? $urandom : 32'hA0000 + ($urandom % 32'h60000);
        acc("R10 random route", a, 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule